// File: doc/BRIEF.md
# Pause Frame Detector

This block sits on the receive side of an Ethernet MAC and looks at every incoming frame for flow-control pause requests. It takes the byte stream with start and end markers, recognises pause control frames by their type and opcode, and checks the destination address. The reserved pause multicast address is always accepted. The station's own unicast address is accepted when that option is enabled.

When a valid pause frame ends with a good CRC and receive flow control is on, the block emits a one-cycle trigger carrying the 16-bit pause time. It loads an internal quanta timer that holds a pause-active level until the requested number of 512-bit-time ticks has gone by. For every frame it also gives a forward or drop decision, so the receive path can keep pause frames out of memory or pass them on.

Top module: `rx_pause_detect`

## Requirements
- R1: A frame is a pause frame only if it has at least 18 bytes, bytes 12..13 are 0x88,0x08 and bytes 14..15 are 0x00,0x01. Byte 0 is the byte marked by rx_sof_i. One cycle after the byte marked by rx_eof_i, dec_valid_o pulses and is_pause_o gives this classification.
- R2: A destination address (bytes 0..5) of 01-80-C2-00-00-01 is always an address match.
- R3: A destination address equal to station_addr_i is an address match only while ucast_det_en_i is 1. Bits [47:40] are compared with byte 0, down to bits [7:0] with byte 5.
- R4: pause_trig_o pulses together with dec_valid_o only for a pause frame with an address match while rx_fc_en_i and rx_crc_ok_i are 1 at the end byte. pause_time_o then holds byte 16 as the high byte and byte 17 as the low byte.
- R5: A frame whose end byte has rx_crc_ok_i = 0 never triggers and leaves pause_active_o unchanged.
- R6: fwd_o is 1 for non-pause frames. For pause frames it depends on fwd_ctrl_i: 00 or 01 drops (0), 10 forwards (1), and 11 forwards only on an address match.
- R7: A trigger with a nonzero time raises pause_active_o in the same cycle as pause_trig_o. Each later quanta_tick_i cycle decrements the timer, and pause_active_o falls after the tick that reaches zero. A new trigger reloads the timer.
- R8: A trigger with pause time 0 clears pause_active_o in the trigger cycle.
- R9: After reset dec_valid_o, pause_trig_o, fwd_o, is_pause_o and pause_active_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_crc_ok_i | input | 1 | CRC good, sampled with the last byte |
| station_addr_i | input | 48 | Programmed station address |
| ucast_det_en_i | input | 1 | Also accept the station address as pause destination |
| rx_fc_en_i | input | 1 | Receive flow control enable |
| fwd_ctrl_i | input | 2 | Pause frame forwarding control |
| quanta_tick_i | input | 1 | One pulse per 512-bit-time quantum |
| dec_valid_o | output | 1 | Per-frame decision strobe |
| is_pause_o | output | 1 | Frame classified as pause |
| fwd_o | output | 1 | 1 forward, 0 drop |
| pause_trig_o | output | 1 | Pause trigger pulse |
| pause_time_o | output | 16 | Extracted pause time |
| pause_active_o | output | 1 | Quanta timer nonzero |

## Verification
The assertions check on every cycle several rules. A trigger always follows a good-CRC end byte seen with flow control enabled. The decision strobe only follows an end byte. A 0x forwarding control never forwards a pause frame. pause_active_o only rises with a trigger and only falls on a tick or a zero-time trigger. Only the bench scenarios can show the content of each decision: the byte-position classification, unicast acceptance gated by its enable, the four forwarding codes, short and padded frames, and the exact tick count before a pause ends, including a reload while active.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned TIME_W     = 16;
  localparam logic [47:0] PAUSE_MC_DA = 48'h0180_C200_0001;
  localparam logic [15:0] ETYPE_MAC_CTRL = 16'h8808;
  localparam logic [15:0] OPC_PAUSE = 16'h0001;

  // byte positions, counted from the first byte of the frame
  localparam int unsigned OFS_TYPE = 12;
  localparam int unsigned OFS_OPC  = 14;
  localparam int unsigned OFS_TIME = 16;
  localparam int unsigned MIN_LAST = OFS_TIME + 1;

  typedef enum logic [1:0] {
    FWD_DROP_A = 2'b00,
    FWD_DROP_B = 2'b01,
    FWD_ALL    = 2'b10,
    FWD_MATCH  = 2'b11
  } fwd_mode_e;

  typedef struct packed {
    logic              is_pause;
    logic              mc_hit;
    logic              uc_hit;
    logic [TIME_W-1:0] ptime;
  } frame_info_t;
endpackage

// File: rtl/rx_pause_parser.sv
module rx_pause_parser
  import rx_pause_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  input  logic        sof_i,
  input  logic        eof_i,
  input  logic [47:0] station_addr_i,
  output logic        done_o,
  output frame_info_t info_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q, idx_c;
  logic             mc_q, mc_c, uc_q, uc_c;
  logic [15:0]      type_q, type_c, opc_q, opc_c, time_q, time_c;

  function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [IDX_W-1:0] i);
    int sh;
    sh = (int'(ADDR_BYTES) - 1 - int'(i)) * 8;
    return a[sh +: 8];
  endfunction

  function automatic logic [15:0] fld_upd(input logic [15:0] cur, input logic [IDX_W-1:0] i,
                                          input int unsigned ofs, input logic [7:0] d);
    logic [15:0] r;
    r = cur;
    if (int'(i) == int'(ofs))          r[15:8] = d;
    else if (int'(i) == int'(ofs) + 1) r[7:0]  = d;
    return r;
  endfunction

  always_comb begin
    idx_c = sof_i ? '0 : idx_q;
    mc_c  = sof_i ? 1'b1 : mc_q;
    uc_c  = sof_i ? 1'b1 : uc_q;
    if (int'(idx_c) < int'(ADDR_BYTES)) begin
      mc_c = mc_c && (data_i == addr_byte(PAUSE_MC_DA, idx_c));
      uc_c = uc_c && (data_i == addr_byte(station_addr_i, idx_c));
    end
    type_c = fld_upd(type_q, idx_c, OFS_TYPE, data_i);
    opc_c  = fld_upd(opc_q,  idx_c, OFS_OPC,  data_i);
    time_c = fld_upd(time_q, idx_c, OFS_TIME, data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mc_q   <= 1'b0;
      uc_q   <= 1'b0;
      type_q <= '0;
      opc_q  <= '0;
      time_q <= '0;
    end else if (valid_i) begin
      idx_q  <= (idx_c == IDX_MAX) ? idx_c : idx_c + 1'b1;
      mc_q   <= mc_c;
      uc_q   <= uc_c;
      type_q <= type_c;
      opc_q  <= opc_c;
      time_q <= time_c;
    end
  end

  assign done_o          = valid_i && eof_i;
  assign info_o.is_pause = (int'(idx_c) >= int'(MIN_LAST)) &&
                           (type_c == ETYPE_MAC_CTRL) && (opc_c == OPC_PAUSE);
  assign info_o.mc_hit   = mc_c;
  assign info_o.uc_hit   = uc_c;
  assign info_o.ptime    = time_c;
endmodule

// File: rtl/rx_pause_filter.sv
module rx_pause_filter
  import rx_pause_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  frame_info_t       info_i,
  input  logic              crc_ok_i,
  input  logic              ucast_en_i,
  input  logic              fc_en_i,
  input  logic [1:0]        fwd_ctrl_i,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o,
  output logic              dec_valid_o,
  output logic              is_pause_o,
  output logic              fwd_o,
  output logic              trig_o,
  output logic [TIME_W-1:0] time_o
);
  logic      hit, fwd_c;
  fwd_mode_e mode;

  assign mode = fwd_mode_e'(fwd_ctrl_i);
  assign hit  = info_i.mc_hit || (ucast_en_i && info_i.uc_hit);

  always_comb begin
    if (!info_i.is_pause) fwd_c = 1'b1;
    else begin
      unique case (mode)
        FWD_ALL:   fwd_c = 1'b1;
        FWD_MATCH: fwd_c = hit;
        default:   fwd_c = 1'b0;
      endcase
    end
  end

  assign load_o     = done_i && info_i.is_pause && hit && fc_en_i && crc_ok_i;
  assign load_val_o = info_i.ptime;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      is_pause_o  <= 1'b0;
      fwd_o       <= 1'b0;
      trig_o      <= 1'b0;
      time_o      <= '0;
    end else begin
      dec_valid_o <= done_i;
      trig_o      <= load_o;
      if (done_i) begin
        is_pause_o <= info_i.is_pause;
        fwd_o      <= fwd_c;
      end
      if (load_o) time_o <= info_i.ptime;
    end
  end
endmodule

// File: rtl/rx_pause_timer.sv
module rx_pause_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;  // reload beats a tick
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rx_pause_detect.sv
module rx_pause_detect
  import rx_pause_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_crc_ok_i,
  input  logic [47:0]       station_addr_i,
  input  logic              ucast_det_en_i,
  input  logic              rx_fc_en_i,
  input  logic [1:0]        fwd_ctrl_i,
  input  logic              quanta_tick_i,
  output logic              dec_valid_o,
  output logic              is_pause_o,
  output logic              fwd_o,
  output logic              pause_trig_o,
  output logic [TIME_W-1:0] pause_time_o,
  output logic              pause_active_o
);
  logic              done;
  frame_info_t       info;
  logic              load;
  logic [TIME_W-1:0] load_val;

  rx_pause_parser #(.IDX_W(IDX_W)) u_parse (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .data_i(rx_data_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i),
    .station_addr_i, .done_o(done), .info_o(info)
  );

  rx_pause_filter u_filt (
    .clk_i, .rst_ni,
    .done_i(done), .info_i(info), .crc_ok_i(rx_crc_ok_i),
    .ucast_en_i(ucast_det_en_i), .fc_en_i(rx_fc_en_i), .fwd_ctrl_i,
    .load_o(load), .load_val_o(load_val),
    .dec_valid_o, .is_pause_o, .fwd_o, .trig_o(pause_trig_o), .time_o(pause_time_o)
  );

  rx_pause_timer #(.CNT_W(TIME_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val), .tick_i(quanta_tick_i),
    .active_o(pause_active_o)
  );
endmodule

// File: rtl/rx_pause_chk.sv
module rx_pause_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic        rx_eof_i,
  input logic        rx_crc_ok_i,
  input logic        rx_fc_en_i,
  input logic [1:0]  fwd_ctrl_i,
  input logic        quanta_tick_i,
  input logic        dec_valid_o,
  input logic        is_pause_o,
  input logic        fwd_o,
  input logic        pause_trig_o,
  input logic [15:0] pause_time_o,
  input logic        pause_active_o
);
  a_r1_dec_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(rx_valid_i && rx_eof_i));

  a_r4_trig_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_trig_o |-> dec_valid_o && is_pause_o && $past(rx_fc_en_i));

  a_r5_trig_needs_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_trig_o |-> $past(rx_crc_ok_i));

  a_r6_drop_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && is_pause_o && !$past(fwd_ctrl_i[1])) |-> !fwd_o);

  a_r7_rise_on_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_active_o) |-> pause_trig_o);

  a_r7_r8_active_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_trig_o |-> (pause_active_o == (pause_time_o != 16'd0)));

  a_r8_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pause_active_o) |-> ($past(quanta_tick_i) || (pause_trig_o && pause_time_o == 16'd0)));
endmodule

bind rx_pause_detect rx_pause_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_eof_i(rx_eof_i),
  .rx_crc_ok_i(rx_crc_ok_i), .rx_fc_en_i(rx_fc_en_i), .fwd_ctrl_i(fwd_ctrl_i),
  .quanta_tick_i(quanta_tick_i), .dec_valid_o(dec_valid_o), .is_pause_o(is_pause_o),
  .fwd_o(fwd_o), .pause_trig_o(pause_trig_o), .pause_time_o(pause_time_o),
  .pause_active_o(pause_active_o)
);

// File: tb/sim_rx_pause_detect.sv
`timescale 1ns/1ps
module sim_rx_pause_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sof = 1'b0, eof = 1'b0, crc_ok = 1'b0;
  logic [7:0]  data = '0;
  logic [47:0] station = 48'h02_11_22_33_44_55;
  logic        ucast_en = 1'b0, fc_en = 1'b1, tick = 1'b0;
  logic [1:0]  fctl = 2'b00;
  logic        dec_valid, is_pause, fwd, trig, active;
  logic [15:0] ptime;

  localparam logic [47:0] MC = 48'h0180_C200_0001;
  localparam logic [47:0] OTHER = 48'h02_99_88_77_66_55;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_pause;
    bit          fwd;
    bit          trig;
    logic [15:0] tm;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rx_pause_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(valid), .rx_data_i(data),
    .rx_sof_i(sof), .rx_eof_i(eof), .rx_crc_ok_i(crc_ok), .station_addr_i(station),
    .ucast_det_en_i(ucast_en), .rx_fc_en_i(fc_en), .fwd_ctrl_i(fctl),
    .quanta_tick_i(tick), .dec_valid_o(dec_valid), .is_pause_o(is_pause),
    .fwd_o(fwd), .pause_trig_o(trig), .pause_time_o(ptime), .pause_active_o(active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare each decision with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && (dec_valid || trig)) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R1: actual unexpected decision expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (!dec_valid || is_pause !== e.is_pause || fwd !== e.fwd || trig !== e.trig ||
            (e.trig && ptime !== e.tm)) begin
          n_bad++;
          $display("FAIL %s: actual v=%0b p=%0b f=%0b t=%0b tm=%0h expected p=%0b f=%0b t=%0b tm=%0h",
                   e.req, dec_valid, is_pause, fwd, trig, ptime, e.is_pause, e.fwd, e.trig, e.tm);
        end
      end
    end
  end

  // driver: builds the frame, pushes the expected result, drives the bytes
  task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                      input logic [15:0] tm, input int len, input bit good, input string req);
    logic [7:0] b[$];
    exp_t e;
    bit hit;
    for (int i = 5; i >= 0; i--) b.push_back(da[8*i +: 8]);
    for (int i = 0; i < 6; i++) b.push_back(8'h20 + 8'(i));
    b.push_back(ty[15:8]); b.push_back(ty[7:0]);
    b.push_back(op[15:8]); b.push_back(op[7:0]);
    b.push_back(tm[15:8]); b.push_back(tm[7:0]);
    while (b.size() < len) b.push_back(8'h00);
    while (b.size() > len) void'(b.pop_back());
    e.is_pause = (len >= 18) && ty == 16'h8808 && op == 16'h0001;
    hit        = (da == MC) || (ucast_en && da == station);
    e.trig     = e.is_pause && hit && fc_en && good;
    e.fwd      = !e.is_pause ? 1'b1 : (fctl == 2'b10) ? 1'b1 : (fctl == 2'b11) ? hit : 1'b0;
    e.tm       = tm;
    e.req      = req;
    sb.push_back(e);
    foreach (b[i]) begin
      @(negedge clk);
      valid  = 1'b1;
      data   = b[i];
      sof    = (i == 0);
      eof    = (i == b.size() - 1);
      crc_ok = eof ? good : 1'b0;
    end
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; eof = 1'b0; crc_ok = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 dec_valid", dec_valid, 0);
    chk("R9 trig", trig, 0);
    chk("R9 active", active, 0);
    chk("R9 fwd", fwd, 0);
    chk("R9 is_pause", is_pause, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R4 R6: multicast pause, drop code 00
    send(MC, 16'h8808, 16'h0001, 16'h0003, 18, 1, "R2_R4");
    chk("R7 active on load", active, 1);
    pulse_tick(); pulse_tick();
    chk("R7 active after 2 of 3 ticks", active, 1);
    pulse_tick();
    chk("R7 inactive after 3 ticks", active, 0);

    // R3 unicast disabled vs enabled
    send(station, 16'h8808, 16'h0001, 16'h0005, 18, 1, "R3_off");
    chk("R3 no trigger when disabled", active, 0);
    ucast_en = 1'b1;
    send(station, 16'h8808, 16'h0001, 16'h0005, 18, 1, "R3_on");
    chk("R3 trigger when enabled", active, 1);

    // R8 zero time ends pause
    send(MC, 16'h8808, 16'h0001, 16'h0000, 18, 1, "R8");
    chk("R8 zero time clears", active, 0);

    // R5 bad CRC
    send(MC, 16'h8808, 16'h0001, 16'h0009, 18, 0, "R5");
    idle(1);
    chk("R5 bad crc no load", active, 0);

    // R4 flow control off
    fc_en = 1'b0;
    send(MC, 16'h8808, 16'h0001, 16'h0009, 18, 1, "R4_fc_off");
    chk("R4 fc off no load", active, 0);
    fc_en = 1'b1;

    // R1 classification
    send(MC, 16'h8808, 16'h0002, 16'h0009, 18, 1, "R1_opcode");
    send(MC, 16'h0800, 16'h0001, 16'h0009, 18, 1, "R1_type");
    send(MC, 16'h8808, 16'h0001, 16'h0009, 17, 1, "R1_short");
    chk("R1 short frame no load", active, 0);
    send(MC, 16'h8808, 16'h0001, 16'h0102, 64, 1, "R1_padded");
    chk("R1 padded frame loads", active, 1);
    send(MC, 16'h8808, 16'h0001, 16'h0000, 18, 1, "R8_clear");

    // R6 forwarding codes
    fctl = 2'b10;
    send(OTHER, 16'h8808, 16'h0001, 16'h0004, 18, 1, "R6_all");
    fctl = 2'b11;
    send(OTHER, 16'h8808, 16'h0001, 16'h0004, 18, 1, "R6_match_miss");
    send(MC, 16'h8808, 16'h0001, 16'h0000, 18, 1, "R6_match_hit");
    fctl = 2'b01;
    send(MC, 16'h8808, 16'h0001, 16'h0000, 18, 1, "R6_drop01");
    send(OTHER, 16'h0800, 16'h0000, 16'h0000, 40, 1, "R6_nonpause");

    // R7 reload while active
    fctl = 2'b00;
    send(MC, 16'h8808, 16'h0001, 16'h0002, 18, 1, "R7_first");
    pulse_tick();
    send(MC, 16'h8808, 16'h0001, 16'h0004, 18, 1, "R7_reload");
    pulse_tick(); pulse_tick(); pulse_tick();
    chk("R7 reload holds after 3 ticks", active, 1);
    pulse_tick();
    chk("R7 reload ends after 4 ticks", active, 0);

    idle(3);
    chk("R1 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule